// File: doc/BRIEF.md
# PMU Power State Sequencer

This block is the digital controller that walks a power management unit through its operating modes. The modes are standby, rail startup, power-on wait, idle, sleep, shutdown and system reset. Three events can wake it: a power switch held long enough, a charger supply appearing, or a clock alarm. A wake is accepted only when a main battery is present and the supply is above its operating threshold. The controller then switches the default rails on in a staggered order and releases the processor reset. After that it waits for the host to confirm with its hold line.

Once the host holds, the block follows the sleep request and keeps watching for fatal conditions. Any of these tears the rails down in the reverse order: the hold line dropping, undervoltage, overheating, or a persistent fault on the monitored rail. A qualified reset-in request causes either a cold restart, which is a full shutdown followed by a prepare delay and a fresh startup, or a hot restart, which keeps the core rails up and only pulses reset-out.

Every millisecond and second interval counts a tick-enable input. The tick period is 0.5 ms by default (`TICKS_PER_MS` = 2). The rail stagger counts system clock cycles (`STAG_CYC`).

Top module: `pmu_seq`

## Requirements
- R1: After reset the block is in standby. The standby state code is 0. `railEn` is 0, `rstOutN` is 0 and `regResetP` is 0.
- R2: In standby, a startup follows once `switchIn` has been high for 100 ms (200 ticks). A shorter high pulse, or one broken by a low cycle, leaves the block in standby and restarts the count from zero.
- R3: A rising edge of `chgValid` starts up at once. An `alarm` pulse starts up after 2 ms (4 ticks). Every start requires `battOk` and `supplyOk` both high, otherwise the block stays in standby.
- R4: The `railEn` bits are assigned as follows: bit 0 is the reference, bit 1 is the LDO5 rail, bit 2 is Buck2 and bit 3 is Buck1. Bits 0 and 1 rise together in startup (code 1). Bit 2 rises `STAG_CYC` cycles later and bit 3 rises 2*`STAG_CYC` cycles later. The block then enters power-on (code 2) with `rstOutN` high, and `rstOutN` is high only while all four bits are set.
- R5: For a non-switch start, `hostHold` high in power-on moves the block to idle (code 3). If `hostHold` is not high within the window measured from startup entry, the block enters shutdown. The window is selected by `holdWinSel`: 0 gives 1.5 s, 1 gives 2 s, 2 gives 4 s and 3 gives 8 s.
- R6: For a switch start, the block stays in power-on for as long as `switchIn` is held, and the window does not apply. Releasing the switch before `hostHold` is high causes a shutdown. Releasing it after idle is reached has no effect.
- R7: In idle, `sleepN` low selects sleep (code 4) and `sleepN` high returns the block to idle. `buck1Code` equals `buck1SleepCode` in sleep and `buck1NormCode` otherwise.
- R8: From idle or sleep, shutdown starts on any of these: `hostHold` low for 10 ms (20 ticks), `uvlo` high, `otHigh` high, or `railFault` high for 10 ms. A low or high glitch shorter than 10 ms has no effect.
- R9: In shutdown (code 5), `rstOutN` is low and Buck1 turns off first. Buck2 turns off `STAG_CYC` cycles later, and the reference and LDO5 turn off 2*`STAG_CYC` cycles after Buck1. The cycle after all rails are off, `regResetP` pulses high for exactly one cycle and the block is in standby.
- R10: From idle or sleep, `rstInN` low for the time selected by `rstTimeSel` requests a system reset. The times are 0 for 0.5 ms, 1 for 1 ms, 2 for 2 ms and 3 for 33 ms. When `coldRst` is 1, the block performs a full shutdown, waits 33 ms in system reset (code 6) and then starts up. When `coldRst` is 0, the rails stay on, `rstOutN` drops and startup is re-entered. Both paths wait for `hostHold` again.
- R11: `auxEn` equals `auxReq` in idle and sleep, and is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable, one cycle per tick period |
| switchIn | input | 1 | Power switch level |
| chgValid | input | 1 | Charger supply valid |
| alarm | input | 1 | Clock alarm event pulse |
| hostHold | input | 1 | Host confirmation line |
| sleepN | input | 1 | Sleep request, active low |
| rstInN | input | 1 | External reset request, active low |
| uvlo | input | 1 | Undervoltage flag |
| otHigh | input | 1 | High over-temperature flag |
| battOk | input | 1 | Main battery detected |
| supplyOk | input | 1 | Supply above operating threshold |
| railFault | input | 1 | Monitored rail fault flag |
| holdWinSel | input | 2 | Host-hold window select |
| rstTimeSel | input | 2 | Reset-in qualification time select |
| coldRst | input | 1 | 1 selects cold reset, 0 selects hot reset |
| auxReq | input | AUX_N | Register-requested enables of the other rails |
| buck1NormCode | input | CODE_W | Buck1 voltage code for normal operation |
| buck1SleepCode | input | CODE_W | Buck1 voltage code for sleep |
| railEn | output | 4 | Core rail enables (reference, LDO5, Buck2, Buck1) |
| auxEn | output | AUX_N | Gated enables of the other rails |
| rstOutN | output | 1 | Processor reset, active low |
| regResetP | output | 1 | One-cycle register default restore pulse |
| buck1Code | output | CODE_W | Selected Buck1 voltage code |
| stateCode | output | 3 | Current operating state |

## Verification
The bench targets the qualification counters with random glitch lengths just under their limits, and with a switch press broken by a single low cycle. A counter that failed to restart would start the unit early. It measures the stagger between rail edges in both directions, so a swapped or mistimed rail would show up as an early Buck1 or a wrong teardown gap. It also checks the host-hold window at two settings, and confirms that a switch start ignores that window, which a design sharing one exit rule for every start would break. Both reset flavours are checked: a hot restart that dropped a core rail, or a cold restart that skipped its prepare wait, would be reported.

// File: rtl/pmu_seq_pkg.sv
package pmu_seq_pkg;

  typedef enum logic [2:0] {
    ST_STBY   = 3'd0,
    ST_START  = 3'd1,
    ST_PWRON  = 3'd2,
    ST_IDLE   = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_SHDN   = 3'd5,
    ST_SYSRST = 3'd6
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrTmr;
    logic clrStg;
    logic seqUp;
    logic seqDown;
    logic auxOn;
    logic sleepSel;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic swQual;
    logic holdLowQual;
    logic faultQual;
    logic rstQual;
    logic alarmGo;
    logic chgEdge;
    logic upDone;
    logic downDone;
    logic winExpired;
    logic prepDone;
  } seqStatus_t;

endpackage

// File: rtl/pmu_seq_dp.sv
module pmu_seq_dp
  import pmu_seq_pkg::*;
#(
  parameter int STAG_CYC     = 128,
  parameter int TICKS_PER_MS = 2,
  parameter int AUX_N        = 6,
  parameter int CODE_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              switchIn,
  input  logic              chgValid,
  input  logic              alarm,
  input  logic              hostHold,
  input  logic              railFault,
  input  logic              rstInN,
  input  logic [1:0]        holdWinSel,
  input  logic [1:0]        rstTimeSel,
  input  logic [AUX_N-1:0]  auxReq,
  input  logic [CODE_W-1:0] buck1NormCode,
  input  logic [CODE_W-1:0] buck1SleepCode,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  output logic [3:0]        railEn,
  output logic [AUX_N-1:0]  auxEn,
  output logic [CODE_W-1:0] buck1Code
);

  localparam int TPM     = TICKS_PER_MS;
  localparam int SW_T    = 100 * TPM;
  localparam int HOLD_T  = 10 * TPM;
  localparam int FLT_T   = 10 * TPM;
  localparam int ALM_T   = 2 * TPM;
  localparam int PREP_T  = 33 * TPM;
  localparam int RST0_T  = (TPM + 1) / 2;
  localparam int Q_MAX   = SW_T;
  localparam int Q_W     = $clog2(Q_MAX + 1);
  localparam int TMR_MAX = 8000 * TPM;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int STG_MAX = 2 * STAG_CYC;
  localparam int STG_W   = $clog2(STG_MAX + 1);
  localparam int ALM_W   = $clog2(ALM_T + 1);

  // level qualifiers: 0 switch high, 1 hold low, 2 fault high, 3 reset-in low
  logic [3:0]     qLvl;
  logic [3:0]     qHit;
  logic [Q_W-1:0] qLim [4];

  assign qLvl = {~rstInN, railFault, ~hostHold, switchIn};

  always_comb begin
    qLim[0] = Q_W'(SW_T);
    qLim[1] = Q_W'(HOLD_T);
    qLim[2] = Q_W'(FLT_T);
    case (rstTimeSel)
      2'd0:    qLim[3] = Q_W'(RST0_T);
      2'd1:    qLim[3] = Q_W'(TPM);
      2'd2:    qLim[3] = Q_W'(2 * TPM);
      default: qLim[3] = Q_W'(PREP_T);
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : gQual
    logic [Q_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             cnt <= '0;
      else if (!qLvl[g])                     cnt <= '0;
      else if (tick && cnt != Q_W'(Q_MAX))   cnt <= cnt + 1'b1;
    end
    assign qHit[g] = qLvl[g] && (cnt >= qLim[g]);
  end

  // tick timer for host window and cold-reset prepare
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] winLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 tmr <= '0;
    else if (strb.clrTmr)                      tmr <= '0;
    else if (tick && tmr != TMR_W'(TMR_MAX))   tmr <= tmr + 1'b1;
  end

  always_comb begin
    case (holdWinSel)
      2'd0:    winLim = TMR_W'(1500 * TPM);
      2'd1:    winLim = TMR_W'(2000 * TPM);
      2'd2:    winLim = TMR_W'(4000 * TPM);
      default: winLim = TMR_W'(8000 * TPM);
    endcase
  end

  // cycle counter for the rail stagger
  logic [STG_W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          stg <= '0;
    else if (strb.clrStg)               stg <= '0;
    else if (stg != STG_W'(STG_MAX))    stg <= stg + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      railEn <= '0;
    end else if (strb.seqUp) begin
      railEn[1:0] <= 2'b11;
      if (stg >= STG_W'(STAG_CYC)) railEn[2] <= 1'b1;
      if (stg >= STG_W'(STG_MAX))  railEn[3] <= 1'b1;
    end else if (strb.seqDown) begin
      railEn[3] <= 1'b0;
      if (stg >= STG_W'(STAG_CYC)) railEn[2]   <= 1'b0;
      if (stg >= STG_W'(STG_MAX))  railEn[1:0] <= 2'b00;
    end
  end

  // alarm start delay
  logic             alarmPend;
  logic [ALM_W-1:0] alarmCnt;
  logic             alarmGo;

  assign alarmGo = alarmPend && (alarmCnt >= ALM_W'(ALM_T));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmPend <= 1'b0;
      alarmCnt  <= '0;
    end else if (alarmGo) begin
      alarmPend <= 1'b0;
    end else if (alarm && !alarmPend) begin
      alarmPend <= 1'b1;
      alarmCnt  <= '0;
    end else if (alarmPend && tick) begin
      alarmCnt <= alarmCnt + 1'b1;
    end
  end

  // charger edge
  logic chgQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chgQ <= 1'b0;
    else       chgQ <= chgValid;
  end

  always_comb begin
    stat.swQual      = qHit[0];
    stat.holdLowQual = qHit[1];
    stat.faultQual   = qHit[2];
    stat.rstQual     = qHit[3];
    stat.alarmGo     = alarmGo;
    stat.chgEdge     = chgValid && !chgQ;
    stat.upDone      = &railEn;
    stat.downDone    = (railEn == 4'b0000);
    stat.winExpired  = (tmr >= winLim);
    stat.prepDone    = (tmr >= TMR_W'(PREP_T));
  end

  assign auxEn     = strb.auxOn ? auxReq : '0;
  assign buck1Code = strb.sleepSel ? buck1SleepCode : buck1NormCode;

endmodule

// File: rtl/pmu_seq_ctl.sv
module pmu_seq_ctl
  import pmu_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepN,
  input  logic       hostHold,
  input  logic       switchIn,
  input  logic       uvlo,
  input  logic       otHigh,
  input  logic       battOk,
  input  logic       supplyOk,
  input  logic       coldRst,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output seqState_t  state,
  output logic       rstOutN,
  output logic       regResetP
);

  seqState_t nxt;
  logic      swKind;
  logic      coldPend;
  logic      killReq;
  logic      startReq;

  assign killReq  = stat.holdLowQual | uvlo | otHigh | stat.faultQual;
  assign startReq = (stat.swQual | stat.chgEdge | stat.alarmGo) & battOk & supplyOk;

  always_comb begin
    nxt = state;
    case (state)
      ST_STBY:  if (startReq) nxt = ST_START;
      ST_START: begin
        if (!supplyOk)        nxt = ST_SHDN;
        else if (stat.upDone) nxt = ST_PWRON;
      end
      ST_PWRON: begin
        if (hostHold)                                nxt = ST_IDLE;
        else if (swKind ? !switchIn : stat.winExpired) nxt = ST_SHDN;
      end
      ST_IDLE, ST_SLEEP: begin
        if (killReq)           nxt = ST_SHDN;
        else if (stat.rstQual) nxt = coldRst ? ST_SHDN : ST_SYSRST;
        else                   nxt = sleepN ? ST_IDLE : ST_SLEEP;
      end
      ST_SHDN:   if (stat.downDone) nxt = coldPend ? ST_SYSRST : ST_STBY;
      ST_SYSRST: if (!coldPend || stat.prepDone) nxt = ST_START;
      default:   nxt = ST_STBY;
    endcase
  end

  always_comb begin
    strb.clrTmr   = (nxt != state) && (nxt == ST_START || nxt == ST_SYSRST);
    strb.clrStg   = (nxt != state);
    strb.seqUp    = (state == ST_START);
    strb.seqDown  = (state == ST_SHDN);
    strb.auxOn    = (state == ST_IDLE) || (state == ST_SLEEP);
    strb.sleepSel = (state == ST_SLEEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_STBY;
      swKind    <= 1'b0;
      coldPend  <= 1'b0;
      regResetP <= 1'b0;
    end else begin
      state     <= nxt;
      regResetP <= (state == ST_SHDN) && (nxt != ST_SHDN);
      if (state == ST_STBY && nxt == ST_START)
        swKind <= !(stat.chgEdge | stat.alarmGo);
      else if (state == ST_SYSRST && nxt == ST_START)
        swKind <= 1'b0;
      if ((state == ST_IDLE || state == ST_SLEEP) && !killReq && stat.rstQual && coldRst)
        coldPend <= 1'b1;
      else if (state == ST_SYSRST && nxt == ST_START)
        coldPend <= 1'b0;
    end
  end

  assign rstOutN = (state == ST_PWRON) || (state == ST_IDLE) || (state == ST_SLEEP);

endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
  import pmu_seq_pkg::*;
#(
  parameter int STAG_CYC     = 128,
  parameter int TICKS_PER_MS = 2,
  parameter int AUX_N        = 6,
  parameter int CODE_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              switchIn,
  input  logic              chgValid,
  input  logic              alarm,
  input  logic              hostHold,
  input  logic              sleepN,
  input  logic              rstInN,
  input  logic              uvlo,
  input  logic              otHigh,
  input  logic              battOk,
  input  logic              supplyOk,
  input  logic              railFault,
  input  logic [1:0]        holdWinSel,
  input  logic [1:0]        rstTimeSel,
  input  logic              coldRst,
  input  logic [AUX_N-1:0]  auxReq,
  input  logic [CODE_W-1:0] buck1NormCode,
  input  logic [CODE_W-1:0] buck1SleepCode,
  output logic [3:0]        railEn,
  output logic [AUX_N-1:0]  auxEn,
  output logic              rstOutN,
  output logic              regResetP,
  output logic [CODE_W-1:0] buck1Code,
  output logic [2:0]        stateCode
);

  seqStrobe_t strb;
  seqStatus_t stat;
  seqState_t  state;

  pmu_seq_ctl uCtl (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .hostHold(hostHold),
    .switchIn(switchIn), .uvlo(uvlo), .otHigh(otHigh), .battOk(battOk),
    .supplyOk(supplyOk), .coldRst(coldRst), .stat(stat), .strb(strb),
    .state(state), .rstOutN(rstOutN), .regResetP(regResetP)
  );

  pmu_seq_dp #(
    .STAG_CYC(STAG_CYC), .TICKS_PER_MS(TICKS_PER_MS),
    .AUX_N(AUX_N), .CODE_W(CODE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .switchIn(switchIn),
    .chgValid(chgValid), .alarm(alarm), .hostHold(hostHold),
    .railFault(railFault), .rstInN(rstInN), .holdWinSel(holdWinSel),
    .rstTimeSel(rstTimeSel), .auxReq(auxReq), .buck1NormCode(buck1NormCode),
    .buck1SleepCode(buck1SleepCode), .strb(strb), .stat(stat),
    .railEn(railEn), .auxEn(auxEn), .buck1Code(buck1Code)
  );

  assign stateCode = state;

endmodule

// File: rtl/pmu_seq_chk.sv
module pmu_seq_chk #(
  parameter int AUX_N = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       railEn,
  input logic [AUX_N-1:0] auxEn,
  input logic             rstOutN,
  input logic             regResetP,
  input logic [2:0]       stateCode
);

  // R4
  core_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstOutN |-> (railEn == 4'hF));

  // R4
  buck1_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    railEn[3] |-> railEn[2]);

  // R9
  buck2_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    railEn[2] |-> (railEn[1] && railEn[0]));

  // R9
  reg_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    regResetP |-> (railEn == 4'h0 && !rstOutN));

  // R9
  reg_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regResetP |=> !regResetP);

  // R11
  aux_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (auxEn != '0) |-> rstOutN);

  // R1
  standby_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd0) |-> (railEn == 4'h0 && !rstOutN));

  // R1
  state_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd6);

endmodule

bind pmu_seq pmu_seq_chk #(.AUX_N(AUX_N)) uChk (
  .clk(clk), .rstN(rstN), .railEn(railEn), .auxEn(auxEn),
  .rstOutN(rstOutN), .regResetP(regResetP), .stateCode(stateCode)
);

// File: tb/pmu_seq_test.sv
module pmu_seq_test;

  localparam int STAG  = 128;
  localparam int TPM   = 2;
  localparam int AUXN  = 6;
  localparam int CW    = 6;
  localparam int TDIV  = 4;
  localparam logic [CW-1:0] NORM_C  = 6'd8;
  localparam logic [CW-1:0] SLEEP_C = 6'd4;

  logic clk = 1'b0;
  logic rstN, tick, switchIn, chgValid, alarm, hostHold, sleepN, rstInN;
  logic uvlo, otHigh, battOk, supplyOk, railFault, coldRst;
  logic [1:0] holdWinSel, rstTimeSel;
  logic [AUXN-1:0] auxReq, auxEn;
  logic [3:0] railEn;
  logic rstOutN, regResetP;
  logic [CW-1:0] buck1Code;
  logic [2:0] stateCode;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pmu_seq #(.STAG_CYC(STAG), .TICKS_PER_MS(TPM), .AUX_N(AUXN), .CODE_W(CW)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .switchIn(switchIn), .chgValid(chgValid),
    .alarm(alarm), .hostHold(hostHold), .sleepN(sleepN), .rstInN(rstInN),
    .uvlo(uvlo), .otHigh(otHigh), .battOk(battOk), .supplyOk(supplyOk),
    .railFault(railFault), .holdWinSel(holdWinSel), .rstTimeSel(rstTimeSel),
    .coldRst(coldRst), .auxReq(auxReq), .buck1NormCode(NORM_C),
    .buck1SleepCode(SLEEP_C), .railEn(railEn), .auxEn(auxEn), .rstOutN(rstOutN),
    .regResetP(regResetP), .buck1Code(buck1Code), .stateCode(stateCode)
  );

  // tick generator
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TDIV - 1);
  end

  // output monitor
  int cyc = 0;
  int upAt [4];
  int dnAt [4];
  int pulseCnt = 0;
  int rstFallCnt = 0;
  int dropCnt = 0;
  logic [3:0] prevRail = 4'h0;
  logic prevRstOut = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (railEn[i] && !prevRail[i]) upAt[i] = cyc;
      if (!railEn[i] && prevRail[i]) begin dnAt[i] = cyc; dropCnt++; end
    end
    if (regResetP) pulseCnt++;
    if (!rstOutN && prevRstOut) rstFallCnt++;
    prevRail   <= railEn;
    prevRstOut <= rstOutN;
  end

  function automatic int expWin(input int sel);
    case (sel)
      0: return 1500 * TPM;
      1: return 2000 * TPM;
      2: return 4000 * TPM;
      default: return 8000 * TPM;
    endcase
  endfunction

  function automatic int expRstLim(input int sel);
    case (sel)
      0: return (TPM + 1) / 2;
      1: return TPM;
      2: return 2 * TPM;
      default: return 33 * TPM;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic chgPulse();
    chgValid = 1'b0; cyc_n(2); chgValid = 1'b1; cyc_n(1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int base, base2;
    void'($urandom(32'd4242));
    rstN = 0; switchIn = 0; chgValid = 0; alarm = 0; hostHold = 0; sleepN = 1;
    rstInN = 1; uvlo = 0; otHigh = 0; battOk = 0; supplyOk = 0; railFault = 0;
    coldRst = 0; holdWinSel = 2'd0; rstTimeSel = 2'd0; auxReq = '0; tick = 0;
    cyc_n(5); rstN = 1; cyc_n(2);

    // R1 reset state
    chk("R1 state", stateCode, 0);
    chk("R1 rails", railEn, 0);
    chk("R1 rstOut", rstOutN, 0);
    chk("R1 regReset", regResetP, 0);

    battOk = 1; supplyOk = 1;
    // R2 random short presses
    for (int k = 0; k < 3; k++) begin
      int len = $urandom_range(5, 180);
      switchIn = 1; ticks(len); switchIn = 0; ticks(3);
      chk("R2 short press", stateCode, 0);
    end
    // R2 press broken by one low cycle restarts the count
    switchIn = 1; ticks(150); switchIn = 0; cyc_n(1); switchIn = 1; ticks(150);
    chk("R2 broken press", stateCode, 0);
    switchIn = 0; cyc_n(2);

    // R3 battery gate
    battOk = 0; chgValid = 1; cyc_n(10);
    chk("R3 no battery", stateCode, 0);
    chgValid = 0; battOk = 1; cyc_n(2);

    // R4 rail order on charger start
    chgValid = 1; cyc_n(2 * STAG + 20);
    chk("R4 ref with ldo5", upAt[0], upAt[1]);
    chk("R4 buck2 stagger", upAt[2] - upAt[1], STAG);
    chk("R4 buck1 stagger", upAt[3] - upAt[1], 2 * STAG);
    chk("R4 power-on state", stateCode, 2);
    chk("R4 rstOut released", rstOutN, 1);

    // R5 window expiry
    base = pulseCnt;
    ticks(expWin(0) - 200);
    chk("R5 inside window", stateCode, 2);
    ticks(300);
    chk("R5 window expired", stateCode, 0);
    // R9 teardown order and register reset pulse
    chk("R9 buck2 off gap", dnAt[2] - dnAt[3], STAG);
    chk("R9 ldo5 off gap", dnAt[1] - dnAt[3], 2 * STAG);
    chk("R9 ref with ldo5", dnAt[0], dnAt[1]);
    chk("R9 one pulse", pulseCnt - base, 1);
    chgValid = 0;

    // R3 alarm start after delay
    alarm = 1; cyc_n(1); alarm = 0;
    ticks(2);
    chk("R3 alarm delay", stateCode, 0);
    ticks(80);
    chk("R3 alarm start", stateCode, 2);
    hostHold = 1; cyc_n(2);
    chk("R5 hold to idle", stateCode, 3);

    // R11 aux enables in idle
    for (int k = 0; k < 3; k++) begin
      auxReq = AUXN'($urandom);
      cyc_n(1);
      chk("R11 aux follow", auxEn, auxReq);
    end

    // R7 sleep
    sleepN = 0; cyc_n(2);
    chk("R7 sleep state", stateCode, 4);
    chk("R7 sleep code", buck1Code, SLEEP_C);
    sleepN = 1; cyc_n(2);
    chk("R7 idle state", stateCode, 3);
    chk("R7 normal code", buck1Code, NORM_C);

    // R8 glitches ignored
    hostHold = 0; ticks(10); hostHold = 1; cyc_n(2);
    chk("R8 hold glitch", stateCode, 3);
    railFault = 1; ticks(12); railFault = 0; cyc_n(2);
    chk("R8 fault glitch", stateCode, 3);
    // R8 undervoltage
    uvlo = 1; cyc_n(2);
    chk("R8 uvlo shutdown", stateCode, 5);
    chk("R9 rstOut low", rstOutN, 0);
    chk("R11 aux off", auxEn, 0);
    uvlo = 0; ticks(80);
    chk("R9 back to standby", stateCode, 0);

    // R6 switch start ignores window while held
    hostHold = 0; switchIn = 1; ticks(285);
    chk("R6 switch start", stateCode, 2);
    ticks(expWin(0));
    chk("R6 held past window", stateCode, 2);
    switchIn = 0; cyc_n(2);
    chk("R6 release shutdown", stateCode, 5);
    ticks(80);
    chk("R6 standby", stateCode, 0);
    switchIn = 1; ticks(285);
    hostHold = 1; cyc_n(2);
    chk("R6 hold while pressed", stateCode, 3);
    switchIn = 0; cyc_n(10);
    chk("R6 release after idle", stateCode, 3);

    // R8 over-temperature
    otHigh = 1; cyc_n(1); otHigh = 0; cyc_n(2);
    chk("R8 ot shutdown", stateCode, 5);
    ticks(80);
    chgPulse(); ticks(80);
    chk("R5 restart to idle", stateCode, 3);

    // R10 hot reset
    coldRst = 0; rstTimeSel = 2'd1;
    rstInN = 0; cyc_n(3); rstInN = 1; cyc_n(5);
    chk("R10 short reset-in", stateCode, 3);
    base = dropCnt; base2 = rstFallCnt;
    rstInN = 0; ticks(expRstLim(1) + 1); rstInN = 1; ticks(80);
    chk("R10 hot rails kept", dropCnt - base, 0);
    chk("R10 hot rstOut pulsed", (rstFallCnt - base2) > 0 ? 1 : 0, 1);
    chk("R10 hot back idle", stateCode, 3);

    // R10 cold reset
    coldRst = 1; rstTimeSel = 2'd0; base = pulseCnt;
    rstInN = 0; ticks(expRstLim(0) + 1); rstInN = 1;
    ticks(70);
    chk("R10 cold prepare", stateCode, 6);
    chk("R10 cold rails off", railEn, 0);
    ticks(40);
    chk("R10 cold still prepare", stateCode, 6);
    ticks(100);
    chk("R10 cold back idle", stateCode, 3);
    chk("R10 cold reg reset", pulseCnt - base, 1);

    // R8 persistent fault
    railFault = 1; ticks(25);
    chk("R8 fault shutdown", stateCode, 5);
    ticks(80); railFault = 0;
    chk("R8 fault standby", stateCode, 0);

    // R5 second window setting
    holdWinSel = 2'd1; hostHold = 0;
    chgPulse();
    ticks(expWin(1) - 500);
    chk("R5 window 2s inside", stateCode, 2);
    ticks(700);
    chk("R5 window 2s expired", stateCode, 0);

    // R3 supply gate
    supplyOk = 0; chgPulse(); cyc_n(10);
    chk("R3 low supply", stateCode, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule